// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This engine protects NAND page data with a single-error-correct, double-error-detect Hamming code. Each 512-byte block of a page gets its own code. The engine sits on the byte stream of a NAND data path and starts work only when a command opens an access at a 512-byte aligned column inside the data area of the page.

During a page write, each finished block produces a 24-bit code word on a one-cycle output strobe, together with the index of its block. The surrounding controller stores these code words in the spare area, behind the data blocks.

During a page read, the stored code word for the block in progress is presented on an input port. At the end of the block it is combined with the freshly computed code. The outcome goes into a per-block status entry: clean, correctable data bit (with its location), error in the stored code word, or uncorrectable. A last-transfer flag closes a short block early.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset every status entry reads zero (valid, corrected, code-error, uncorrectable and location) and `codeValid` is low.
- R2: A command arms the engine only when `cmdCol[8:0]` is zero and `cmdCol` is below NUM_BLOCKS*512. The starting block is `cmdCol[10:9]`. A command that fails either test has no effect, and bytes arriving while the engine is not armed are ignored.
- R3: The code word has 12 bit pairs. Pair p sits at bits [2p+1:2p]: the even member at 2p, the odd member at 2p+1. Pairs 0..2 cover bit b of the bit position within a byte. Pairs 3..11 cover bit k of the 9-bit byte index within the block. The odd member is the XOR of all data bits whose position or index has that bit set, and the even member is the XOR of the remaining data bits.
- R4: During a write, the cycle after the 512th byte of a block, `codeValid` is high for one cycle with `codeOut` holding that block's code and `codeBlk` its index. The next byte begins the following block from a fresh state, and write completions leave the status entries untouched.
- R5: During a read, the syndrome is `storedCode` (sampled with the block's final byte) XOR the computed code. A zero syndrome sets only that block's valid flag.
- R6: A syndrome with every pair complementary marks the block as corrected. Its location field is byte_index*8 + bit_position, formed from the odd members of the pairs.
- R7: A syndrome with exactly one bit set marks the block with the code-error flag and a location of zero.
- R8: Any other non-zero syndrome marks the block as uncorrectable.
- R9: A byte carrying `byteLast` closes the current block at whatever length it has reached. The result (code or status) is produced as for a full block, and the engine then disarms.
- R10: After the block with index NUM_BLOCKS-1 completes, the engine disarms.
- R11: An arming command clears every status entry. If it arrives in the same cycle as a block's final byte, that byte still finishes the old operation: a write still emits its code, but a read's status update is lost to the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe opening a page access |
| cmdWrite | input | 1 | 1 = write access, 0 = read access |
| cmdCol | input | COL_W | Column address of the access |
| byteValid | input | 1 | Data byte present |
| byteData | input | 8 | Data byte |
| byteLast | input | 1 | Final byte of the transfer |
| storedCode | input | 24 | Stored code word for the block being read |
| codeValid | output | 1 | One-cycle strobe for a finished write code word |
| codeOut | output | 24 | Generated code word |
| codeBlk | output | BLK_W | Block index of `codeOut` |
| blkValid | output | NUM_BLOCKS | Per-block check result present |
| blkCorr | output | NUM_BLOCKS | Per-block single data-bit error found |
| blkCodeErr | output | NUM_BLOCKS | Per-block error in stored code word |
| blkUncorr | output | NUM_BLOCKS | Per-block uncorrectable error |
| blkLoc | output | NUM_BLOCKS*12 | Per-block error location, 12 bits each |

## Verification
Two events can land in the same cycle: a block's final byte finishing an operation, and an aligned command starting a new one. The bench drives both on one clock edge. It does this once with a write in flight, where the code strobe must still appear with the correct value. It does it again with a read in flight, where the block's status must stay clear. Around that case, the bench sweeps every single data-bit flip of a short block and every single flipped code bit, and checks the reported location or flag against values computed from the bit-pair rule.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int BYTE_W      = 8;
  localparam int BIT_W       = $clog2(BYTE_W);
  localparam int BLOCK_BYTES = 512;
  localparam int IDX_W       = $clog2(BLOCK_BYTES);
  localparam int PAIRS       = BIT_W + IDX_W;
  localparam int CODE_W      = 2 * PAIRS;
  localparam int LOC_W       = IDX_W + BIT_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [1:0] {SYN_CLEAN, SYN_DATA, SYN_CODE, SYN_FATAL} syn_kind_e;

  typedef struct packed {
    syn_kind_e         kind;
    logic [LOC_W-1:0]  loc;
  } syn_res_t;

  // strobes from control to datapath
  typedef struct packed {
    logic take;     // accept current byte
    logic fin;      // current byte closes the block
    logic restart;  // aligned command: new page operation
    logic isWrite;  // operation in progress is a write
  } ecc_stb_t;

  // fold one byte into the running pair-parity code
  function automatic code_t foldByte(code_t acc, idx_t idx, logic [BYTE_W-1:0] d);
    code_t c;
    logic  p;
    logic  hi;
    logic  lo;
    c = acc;
    p = ^d;
    for (int b = 0; b < BIT_W; b++) begin
      hi = 1'b0;
      lo = 1'b0;
      for (int j = 0; j < BYTE_W; j++) begin
        if (j[b]) hi = hi ^ d[j];
        else      lo = lo ^ d[j];
      end
      c[2*b]   = c[2*b] ^ lo;
      c[2*b+1] = c[2*b+1] ^ hi;
    end
    for (int k = 0; k < IDX_W; k++) begin
      if (idx[k]) c[2*(BIT_W+k)+1] = c[2*(BIT_W+k)+1] ^ p;
      else        c[2*(BIT_W+k)]   = c[2*(BIT_W+k)] ^ p;
    end
    return c;
  endfunction

  // classify a syndrome
  function automatic syn_res_t decodeSyn(code_t s);
    syn_res_t r;
    logic     pairsOk;
    pairsOk = 1'b1;
    for (int p = 0; p < PAIRS; p++) begin
      pairsOk  = pairsOk & (s[2*p] ^ s[2*p+1]);
      r.loc[p] = s[2*p+1];
    end
    if (s == '0)                 r.kind = SYN_CLEAN;
    else if ($countones(s) == 1) r.kind = SYN_CODE;
    else if (pairsOk)            r.kind = SYN_DATA;
    else                         r.kind = SYN_FATAL;
    if (r.kind != SYN_DATA) r.loc = '0;
    return r;
  endfunction
endpackage

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int COL_W      = 12,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [COL_W-1:0] cmdCol,
  input  logic             byteValid,
  input  logic             byteLast,
  output ecc_stb_t         stb,
  output idx_t             byteIdx,
  output logic [BLK_W-1:0] blk
);
  localparam idx_t IDX_LAST = idx_t'(BLOCK_BYTES - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(NUM_BLOCKS - 1);

  logic             armed;
  logic             isWriteQ;
  logic [BLK_W-1:0] blkQ;
  idx_t             idxQ;
  logic             aligned;
  logic             inData;

  always_comb begin
    aligned     = (cmdCol[IDX_W-1:0] == '0);
    inData      = ((cmdCol >> (IDX_W + BLK_W)) == '0);
    stb.restart = cmdValid && aligned && inData;
    stb.take    = armed && byteValid;
    stb.fin     = stb.take && (byteLast || idxQ == IDX_LAST);
    stb.isWrite = isWriteQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      isWriteQ <= 1'b0;
      blkQ     <= '0;
      idxQ     <= '0;
    end else if (stb.restart) begin
      armed    <= 1'b1;
      isWriteQ <= cmdWrite;
      blkQ     <= cmdCol[IDX_W +: BLK_W];
      idxQ     <= '0;
    end else if (stb.fin) begin
      idxQ <= '0;
      if (byteLast || blkQ == BLK_LAST) armed <= 1'b0;
      else                              blkQ  <= blkQ + 1'b1;
    end else if (stb.take) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  assign byteIdx = idxQ;
  assign blk     = blkQ;

  // R2: misaligned command cannot arm an idle engine
  p_unaligned_noarm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && cmdValid && cmdCol[IDX_W-1:0] != '0) |=> !armed);

  // R9: last-flagged byte disarms unless a new command arrives
  p_last_disarms_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && byteValid && byteLast && !cmdValid) |=> !armed);

  // R10: final block disarms
  p_final_blk_disarms_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && byteValid && idxQ == IDX_LAST && blkQ == BLK_LAST && !cmdValid) |=> !armed);
endmodule

// File: rtl/ecc_dp.sv
module ecc_dp
  import nand_ecc_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ecc_stb_t                    stb,
  input  idx_t                        byteIdx,
  input  logic [BLK_W-1:0]            blk,
  input  logic [BYTE_W-1:0]           byteData,
  input  code_t                       storedCode,
  output logic                        codeValid,
  output code_t                       codeOut,
  output logic [BLK_W-1:0]            codeBlk,
  output logic [NUM_BLOCKS-1:0]       blkValid,
  output logic [NUM_BLOCKS-1:0]       blkCorr,
  output logic [NUM_BLOCKS-1:0]       blkCodeErr,
  output logic [NUM_BLOCKS-1:0]       blkUncorr,
  output logic [NUM_BLOCKS*LOC_W-1:0] blkLoc
);
  code_t    acc;
  code_t    finalCode;
  syn_res_t res;

  always_comb begin
    finalCode = foldByte(acc, byteIdx, byteData);
    res       = decodeSyn(finalCode ^ storedCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      codeValid <= 1'b0;
      codeOut   <= '0;
      codeBlk   <= '0;
    end else begin
      if (stb.restart || stb.fin) acc <= '0;
      else if (stb.take)          acc <= finalCode;
      codeValid <= stb.fin && stb.isWrite;
      if (stb.fin && stb.isWrite) begin
        codeOut <= finalCode;
        codeBlk <= blk;
      end
    end
  end

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN || stb.restart) begin
        blkValid[i]                 <= 1'b0;
        blkCorr[i]                  <= 1'b0;
        blkCodeErr[i]               <= 1'b0;
        blkUncorr[i]                <= 1'b0;
        blkLoc[i*LOC_W +: LOC_W]    <= '0;
      end else if (stb.fin && !stb.isWrite && blk == BLK_W'(i)) begin
        blkValid[i]                 <= 1'b1;
        blkCorr[i]                  <= (res.kind == SYN_DATA);
        blkCodeErr[i]               <= (res.kind == SYN_CODE);
        blkUncorr[i]                <= (res.kind == SYN_FATAL);
        blkLoc[i*LOC_W +: LOC_W]    <= res.loc;
      end
    end

    // R8: at most one outcome flag per block
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({blkCorr[i], blkCodeErr[i], blkUncorr[i]}));

    // R5: an outcome flag implies the entry is valid
    p_flag_needs_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
      (blkCorr[i] || blkCodeErr[i] || blkUncorr[i]) |-> blkValid[i]);
  end

  // R11: a new page operation clears all status
  p_clear_on_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (blkValid == '0));

  // R4: write completions leave the status untouched
  p_write_keeps_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fin && stb.isWrite && !stb.restart) |=> $stable(blkValid));

  // R4: a code strobe only follows a block completion
  p_code_after_fin_r4: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> $past(stb.fin));
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nand_ecc_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int COL_W      = 12,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic                        cmdWrite,
  input  logic [COL_W-1:0]            cmdCol,
  input  logic                        byteValid,
  input  logic [BYTE_W-1:0]           byteData,
  input  logic                        byteLast,
  input  logic [CODE_W-1:0]           storedCode,
  output logic                        codeValid,
  output logic [CODE_W-1:0]           codeOut,
  output logic [BLK_W-1:0]            codeBlk,
  output logic [NUM_BLOCKS-1:0]       blkValid,
  output logic [NUM_BLOCKS-1:0]       blkCorr,
  output logic [NUM_BLOCKS-1:0]       blkCodeErr,
  output logic [NUM_BLOCKS-1:0]       blkUncorr,
  output logic [NUM_BLOCKS*LOC_W-1:0] blkLoc
);
  ecc_stb_t         stb;
  idx_t             byteIdx;
  logic [BLK_W-1:0] blk;

  ecc_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .COL_W(COL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdCol(cmdCol), .byteValid(byteValid), .byteLast(byteLast),
    .stb(stb), .byteIdx(byteIdx), .blk(blk)
  );

  ecc_dp #(.NUM_BLOCKS(NUM_BLOCKS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIdx(byteIdx), .blk(blk),
    .byteData(byteData), .storedCode(storedCode),
    .codeValid(codeValid), .codeOut(codeOut), .codeBlk(codeBlk),
    .blkValid(blkValid), .blkCorr(blkCorr), .blkCodeErr(blkCodeErr),
    .blkUncorr(blkUncorr), .blkLoc(blkLoc)
  );
endmodule

// File: tb/nand_hamming_ecc_tb.sv
module nand_hamming_ecc_tb_top;
  import nand_ecc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rstN;
  logic cmdValid, cmdWrite, byteValid, byteLast;
  logic [CW-1:0] cmdCol;
  logic [7:0] byteData;
  logic [23:0] storedCode, codeOut;
  logic codeValid;
  logic [1:0] codeBlk;
  logic [NB-1:0] blkValid, blkCorr, blkCodeErr, blkUncorr;
  logic [NB*12-1:0] blkLoc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] blkBuf [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_hamming_ecc dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdCol(cmdCol),
    .byteValid(byteValid), .byteData(byteData), .byteLast(byteLast),
    .storedCode(storedCode), .codeValid(codeValid), .codeOut(codeOut), .codeBlk(codeBlk),
    .blkValid(blkValid), .blkCorr(blkCorr), .blkCodeErr(blkCodeErr),
    .blkUncorr(blkUncorr), .blkLoc(blkLoc)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkStat(string tag, int b, int v, int c, int ce, int u, int loc);
    check({tag, " valid"},   int'(blkValid[b]), v);
    check({tag, " corr"},    int'(blkCorr[b]), c);
    check({tag, " codeErr"}, int'(blkCodeErr[b]), ce);
    check({tag, " uncorr"},  int'(blkUncorr[b]), u);
    check({tag, " loc"},     int'(blkLoc[b*12 +: 12]), loc);
  endtask

  function automatic void fillBuf(int seed);
    for (int i = 0; i < 512; i++)
      blkBuf[i] = 8'(((i * 37) + (seed * 91) + ((i >> 4) * 5)) ^ seed);
  endfunction

  // expected code from the per-bit pair rule
  function automatic logic [23:0] refCode(int n);
    logic [23:0] c;
    c = '0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++)
        if (blkBuf[i][j]) begin
          for (int b = 0; b < 3; b++) c[2*b + ((j >> b) & 1)] ^= 1'b1;
          for (int k = 0; k < 9; k++) c[2*(3+k) + ((i >> k) & 1)] ^= 1'b1;
        end
    return c;
  endfunction

  task automatic issueCmd(bit wr, int col);
    @(negedge clk);
    cmdValid = 1'b1; cmdWrite = wr; cmdCol = CW'(col);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // stream n bytes; returns at the negedge after the last byte's edge
  task automatic streamBytes(int n, bit withLast);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = blkBuf[i];
      byteLast = withLast && (i == n - 1);
    end
    @(negedge clk);
    byteValid = 1'b0; byteLast = 1'b0;
  endtask

  // last byte of n shares its cycle with an aligned command at column 0
  task automatic streamCollide(int n, bit newWr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = blkBuf[i];
      byteLast = (i == n - 1);
      if (i == n - 1) begin
        cmdValid = 1'b1; cmdWrite = newWr; cmdCol = '0;
      end
    end
    @(negedge clk);
    byteValid = 1'b0; byteLast = 1'b0; cmdValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] ref0;
    rstN = 1'b0; cmdValid = 0; cmdWrite = 0; cmdCol = '0;
    byteValid = 0; byteData = '0; byteLast = 0; storedCode = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 codeValid", int'(codeValid), 0);
    check("R1 blkValid", int'(blkValid), 0);
    check("R1 blkLoc", int'(blkLoc[23:0]), 0);

    // R2 misaligned and out-of-data-area commands, unarmed bytes ignored
    fillBuf(1);
    issueCmd(1, 12'h005);
    streamBytes(4, 1);
    check("R2 misaligned no code", int'(codeValid), 0);
    issueCmd(1, 12'h800);
    streamBytes(4, 1);
    check("R2 spare column no code", int'(codeValid), 0);

    // R3 R4 four full write blocks
    issueCmd(1, 0);
    for (int b = 0; b < 4; b++) begin
      fillBuf(10 + b);
      streamBytes(512, 0);
      check("R4 codeValid", int'(codeValid), 1);
      check("R3 code value", int'(codeOut), int'(refCode(512)));
      check("R4 codeBlk", int'(codeBlk), b);
      check("R4 status untouched", int'(blkValid), 0);
      @(negedge clk);
      check("R4 single pulse", int'(codeValid), 0);
    end
    // R10 disarmed after last block
    streamBytes(4, 1);
    check("R10 no code after final block", int'(codeValid), 0);

    // R2 start at block 2, R9 short last block then disarm
    issueCmd(1, 12'h400);
    fillBuf(7);
    streamBytes(512, 0);
    check("R2 start block index", int'(codeBlk), 2);
    check("R3 code block2", int'(codeOut), int'(refCode(512)));
    fillBuf(8);
    streamBytes(100, 1);
    check("R9 short code valid", int'(codeValid), 1);
    check("R9 short code value", int'(codeOut), int'(refCode(100)));
    check("R9 short codeBlk", int'(codeBlk), 3);
    streamBytes(4, 1);
    check("R9 disarmed after last", int'(codeValid), 0);

    // R5 clean full read, then R6 full block with flipped byte 300 bit 5
    issueCmd(0, 0);
    fillBuf(3);
    storedCode = refCode(512);
    streamBytes(512, 0);
    fillBuf(4);
    storedCode = refCode(512);
    blkBuf[300] ^= 8'h20;
    streamBytes(512, 0);
    checkStat("R5 clean block0", 0, 1, 0, 0, 0, 0);
    checkStat("R6 block1 flip", 1, 1, 1, 0, 0, 300*8 + 5);
    check("R5 untouched blocks", int'(blkValid[3:2]), 0);
    check("R4 read emits no code", int'(codeValid), 0);

    // R6 sweep every single data-bit flip of a 4-byte block
    for (int f = 0; f < 32; f++) begin
      fillBuf(20 + f);
      storedCode = refCode(4);
      blkBuf[f/8] ^= 8'(1 << (f % 8));
      issueCmd(0, 0);
      streamBytes(4, 1);
      checkStat("R6 data flip", 0, 1, 1, 0, 0, f);
    end

    // R7 sweep every single stored-code bit flip
    for (int b = 0; b < 24; b++) begin
      fillBuf(60 + b);
      storedCode = refCode(4) ^ (24'h1 << b);
      issueCmd(0, 0);
      streamBytes(4, 1);
      checkStat("R7 code flip", 0, 1, 0, 1, 0, 0);
    end

    // R8 double errors
    for (int f = 0; f < 20; f++) begin
      fillBuf(90 + f);
      storedCode = refCode(4);
      blkBuf[f/8] ^= 8'(1 << (f % 8));
      blkBuf[(f+9)/8] ^= 8'(1 << ((f+9) % 8));
      issueCmd(0, 0);
      streamBytes(4, 1);
      checkStat("R8 double data", 0, 1, 0, 0, 1, 0);
    end
    fillBuf(5);
    storedCode = refCode(4) ^ 24'h000003;
    issueCmd(0, 0);
    streamBytes(4, 1);
    checkStat("R8 double code", 0, 1, 0, 0, 1, 0);

    // R11 plain clear
    issueCmd(1, 0);
    check("R11 status cleared", int'(blkValid), 0);

    // R11 collision: write finishes while a read command arrives
    fillBuf(33);
    ref0 = refCode(4);
    streamCollide(4, 0);
    check("R11 collide write code valid", int'(codeValid), 1);
    check("R11 collide write code", int'(codeOut), int'(ref0));
    // engine now armed for read; read finishes as a write command arrives
    storedCode = ref0;
    streamCollide(4, 1);
    check("R11 collide read cleared", int'(blkValid), 0);
    check("R11 collide no code", int'(codeValid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule